// File: doc/BRIEF.md
# Inverter Sector and Clamp Selector

This block sits in the modulator of a three-phase, three-level inverter whose legs can connect each output to the positive rail, the dc midpoint, or the negative rail. Once per carrier period it takes the three signed phase references and works out which 60-degree operating region is active from their signs alone. From the region it names the one phase that stays tied to a rail for the whole region, and whether that rail is the positive or the negative one. In the remaining regions of the pattern, the odd regions tie the lone negative phase low and the even regions tie the lone positive phase high.

The two phases that are not clamped are the active ones. Each forms a line voltage with the clamped phase. For each of these two line voltages the block reports whether the magnitude reaches half the dc bus (E) or stays below it. The downstream pulse generator uses that to pick the pair of levels its single carrier switches between. All outputs are registered on a one-cycle sample strobe and hold between strobes.

Top module: `clamp_region_sel`

## Requirements
- R1: While rst_n is low, and until the first accepted strobe, region is 1, clamp_phase is 1, clamp_hi is 0, and lvl_p and lvl_n are 0.
- R2: A phase is positive when its sign bit is clear. With signs listed as (A,B,C), the region code is as follows: (+,-,+) gives 1, (+,-,-) gives 2, (+,+,-) gives 3, (-,+,-) gives 4, (-,+,+) gives 5, and (-,-,+) gives 6.
- R3: A reference of exactly zero counts as positive in the region decode.
- R4: The clamped phase is the one whose sign differs from the other two. For odd regions this is the lone negative phase and clamp_hi is 0 (negative rail). For even regions it is the lone positive phase and clamp_hi is 1 (positive rail).
- R5: clamp_phase encodes A as 0, B as 1 and C as 2. The code 3 never appears.
- R6: The active phases are the two unclamped ones. lvl_p refers to the lower-indexed one and lvl_n to the higher-indexed one. A flag is 1 when the line voltage magnitude |v_active - v_clamped| is at least 2^FRAC (E), and 0 otherwise. A magnitude of exactly E gives 1.
- R7: Outputs take new values only at a rising clk edge where sample_stb is 1, and become visible right after that edge. Without a strobe they hold.
- R8: A strobe with all three references of the same sign is ignored, and all outputs keep their previous values.
- R9: The region output is always in the range 1 to 6. The codes 0 and 7 never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_stb | input | 1 | One-cycle strobe that captures a new decision |
| ref_a | input | W | Phase A reference, signed, E = 2^FRAC |
| ref_b | input | W | Phase B reference, signed |
| ref_c | input | W | Phase C reference, signed |
| region | output | 3 | Operating region, 1 to 6 |
| clamp_phase | output | 2 | Clamped phase: 0 = A, 1 = B, 2 = C |
| clamp_hi | output | 1 | 1 = clamped to the positive rail, 0 = clamped to the negative rail |
| lvl_p | output | 1 | Lower-indexed active line voltage is at or above E |
| lvl_n | output | 1 | Higher-indexed active line voltage is at or above E |

## Verification
The bench uses the default W = 16 and FRAC = 13, so E is 8192 and a full 2E line swing of 16384 still fits without saturation. Line magnitudes can therefore be driven exactly onto E and one count below it, in both the lower- and the higher-indexed flag. All six regions are covered, along with zero-valued references sitting on region edges and both same-sign patterns that have to be rejected.

// File: rtl/clamp_region_pkg.sv
package clamp_region_pkg;

  localparam int unsigned NPH = 3;

  // sign vector: bit k set when phase k is non-negative (k: 0=A,1=B,2=C)
  function automatic logic [2:0] region_of(input logic [2:0] pos);
    logic [2:0] r;
    case (pos)
      3'b101:  r = 3'd1;
      3'b001:  r = 3'd2;
      3'b011:  r = 3'd3;
      3'b010:  r = 3'd4;
      3'b110:  r = 3'd5;
      3'b100:  r = 3'd6;
      default: r = 3'd0;
    endcase
    return r;
  endfunction

  function automatic logic majority(input logic [2:0] pos);
    return (pos[0] & pos[1]) | (pos[0] & pos[2]) | (pos[1] & pos[2]);
  endfunction

  // index of the phase whose sign differs from the majority
  function automatic logic [1:0] odd_one(input logic [2:0] pos);
    logic m;
    logic [1:0] k;
    m = majority(pos);
    if (pos[0] != m)      k = 2'd0;
    else if (pos[1] != m) k = 2'd1;
    else                  k = 2'd2;
    return k;
  endfunction

  // magnitude of an active line voltage with one extra bit of headroom
  function automatic logic signed [16:0] line_mag17(input logic signed [15:0] v_act,
                                                   input logic signed [15:0] v_clp,
                                                   input logic hi);
    logic signed [16:0] a;
    logic signed [16:0] c;
    a = {v_act[15], v_act};
    c = {v_clp[15], v_clp};
    return hi ? (c - a) : (a - c);
  endfunction

endpackage

// File: rtl/region_decoder.sv
module region_decoder
  import clamp_region_pkg::*;
(
  input  logic [2:0] pos,
  output logic [2:0] region_d,
  output logic [1:0] clamp_d,
  output logic       hi_d,
  output logic [1:0] act_p,
  output logic [1:0] act_n,
  output logic       bad
);
  always_comb begin
    region_d = region_of(pos);
    bad      = (pos == 3'b000) || (pos == 3'b111);
    clamp_d  = odd_one(pos);
    hi_d     = ~majority(pos);
    case (clamp_d)
      2'd0:    begin act_p = 2'd1; act_n = 2'd2; end
      2'd1:    begin act_p = 2'd0; act_n = 2'd2; end
      default: begin act_p = 2'd0; act_n = 2'd1; end
    endcase
  end
endmodule

// File: rtl/line_level_cmp.sv
module line_level_cmp #(
  parameter int W    = 16,
  parameter int FRAC = 13
) (
  input  logic signed [W-1:0] v_act,
  input  logic signed [W-1:0] v_clp,
  input  logic                clamp_hi,
  output logic                at_or_above
);
  localparam logic signed [W:0] HALF_BUS = {{(W-FRAC){1'b0}}, 1'b1, {FRAC{1'b0}}};

  logic signed [W:0] a_x;
  logic signed [W:0] c_x;
  logic signed [W:0] mag;

  always_comb begin
    a_x = {v_act[W-1], v_act};
    c_x = {v_clp[W-1], v_clp};
    mag = clamp_hi ? (c_x - a_x) : (a_x - c_x);
    at_or_above = (mag >= HALF_BUS);
  end
endmodule

// File: rtl/clamp_region_sel.sv
module clamp_region_sel
  import clamp_region_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_stb,
  input  logic signed [W-1:0] ref_a,
  input  logic signed [W-1:0] ref_b,
  input  logic signed [W-1:0] ref_c,
  output logic [2:0]          region,
  output logic [1:0]          clamp_phase,
  output logic                clamp_hi,
  output logic                lvl_p,
  output logic                lvl_n
);
  localparam int NACT = 2;

  logic signed [W-1:0] ph [NPH];
  logic [2:0] pos;
  logic [2:0] region_d;
  logic [1:0] clamp_d;
  logic       hi_d;
  logic [1:0] act_idx [NACT];
  logic [NACT-1:0] lvl_d;
  logic       pat_bad;
  logic       take;

  assign ph[0] = ref_a;
  assign ph[1] = ref_b;
  assign ph[2] = ref_c;

  for (genvar k = 0; k < NPH; k++) begin : g_sign
    assign pos[k] = ~ph[k][W-1];
  end

  region_decoder u_dec (
    .pos      (pos),
    .region_d (region_d),
    .clamp_d  (clamp_d),
    .hi_d     (hi_d),
    .act_p    (act_idx[0]),
    .act_n    (act_idx[1]),
    .bad      (pat_bad)
  );

  for (genvar j = 0; j < NACT; j++) begin : g_lvl
    line_level_cmp #(.W(W), .FRAC(FRAC)) u_cmp (
      .v_act       (ph[act_idx[j]]),
      .v_clp       (ph[clamp_d]),
      .clamp_hi    (hi_d),
      .at_or_above (lvl_d[j])
    );
  end

  assign take = sample_stb & ~pat_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region      <= 3'd1;
      clamp_phase <= 2'd1;
      clamp_hi    <= 1'b0;
      lvl_p       <= 1'b0;
      lvl_n       <= 1'b0;
    end else if (take) begin
      region      <= region_d;
      clamp_phase <= clamp_d;
      clamp_hi    <= hi_d;
      lvl_p       <= lvl_d[0];
      lvl_n       <= lvl_d[1];
    end
  end
endmodule

// File: rtl/clamp_region_sel_chk.sv
module clamp_region_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sample_stb,
  input logic       pat_bad,
  input logic [2:0] region,
  input logic [1:0] clamp_phase,
  input logic       clamp_hi,
  input logic       lvl_p,
  input logic       lvl_n
);
  logic [7:0] state_q;
  assign state_q = {region, clamp_phase, clamp_hi, lvl_p, lvl_n};

  // R9
  region_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region >= 3'd1) && (region <= 3'd6));

  // R5
  phase_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_phase != 2'd3);

  // R4
  rail_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_hi == ~region[0]);

  // R4
  phase_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 3'd1 || region == 3'd4) |-> clamp_phase == 2'd1);

  // R4
  phase_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 3'd2 || region == 3'd5) |-> clamp_phase == 2'd0);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(state_q));

  // R8
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && pat_bad) |=> $stable(state_q));
endmodule

bind clamp_region_sel clamp_region_sel_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_stb  (sample_stb),
  .pat_bad     (pat_bad),
  .region      (region),
  .clamp_phase (clamp_phase),
  .clamp_hi    (clamp_hi),
  .lvl_p       (lvl_p),
  .lvl_n       (lvl_n)
);

// File: tb/clamp_region_sel_test.sv
`timescale 1ns/1ps
module clamp_region_sel_test;
  localparam int W = 16;
  localparam int FRAC = 13;
  localparam int NV = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_stb = 1'b0;
  logic signed [W-1:0] ref_a = '0, ref_b = '0, ref_c = '0;
  logic [2:0] region;
  logic [1:0] clamp_phase;
  logic clamp_hi, lvl_p, lvl_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  clamp_region_sel #(.W(W), .FRAC(FRAC)) uut (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .region(region), .clamp_phase(clamp_phase), .clamp_hi(clamp_hi),
    .lvl_p(lvl_p), .lvl_n(lvl_n)
  );

  // stimulus and expected outputs; E = 8192
  localparam int VA [NV] = '{ 4096,  2000,  8192,  5000,  3000, -1000, -5000, -2000, 0};
  localparam int VB [NV] = '{-8192, -3000,  -100, -3192,  3000,  7000,     0, -2000, -1};
  localparam int VC [NV] = '{ 4096,  1000, -8192, -3191, -6000, -1192,  5000,  4000, 0};
  localparam int XR [NV] = '{1, 1, 2, 2, 3, 4, 5, 6, 1};
  localparam int XP [NV] = '{1, 1, 0, 0, 2, 1, 0, 2, 1};
  localparam int XH [NV] = '{0, 0, 1, 1, 0, 1, 0, 1, 0};
  localparam int XLP[NV] = '{1, 0, 1, 1, 1, 0, 0, 0, 0};
  localparam int XLN[NV] = '{1, 0, 1, 0, 1, 1, 1, 0, 0};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pack_out();
    return {region, clamp_phase, clamp_hi, lvl_p, lvl_n};
  endfunction

  task automatic strobe(input int a, input int b, input int c);
    @(negedge clk);
    ref_a = W'(a); ref_b = W'(b); ref_c = W'(c);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
  endtask

  initial begin : watchdog
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int snap;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 region", int'(region), 1);
    check("R1 clamp_phase", int'(clamp_phase), 1);
    check("R1 clamp_hi", int'(clamp_hi), 0);
    check("R1 lvl_p", int'(lvl_p), 0);
    check("R1 lvl_n", int'(lvl_n), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", pack_out(), {3'd1, 2'd1, 1'b0, 1'b0, 1'b0});

    // R2 R3 R4 R5 R6 R9 table walk
    for (int i = 0; i < NV; i++) begin
      strobe(VA[i], VB[i], VC[i]);
      check("R2 region", int'(region), XR[i]);
      check("R4 R5 clamp_phase", int'(clamp_phase), XP[i]);
      check("R4 clamp_hi", int'(clamp_hi), XH[i]);
      check("R6 lvl_p", int'(lvl_p), XLP[i]);
      check("R6 lvl_n", int'(lvl_n), XLN[i]);
      check("R9 region range", int'(region >= 3'd1 && region <= 3'd6), 1);
    end

    // R3: zero on phase B turns region 6 pattern into region 5
    strobe(-3000, 0, 3000);
    check("R3 zero positive", int'(region), 5);

    // R7: input change without strobe holds outputs
    strobe(3000, 3000, -6000);
    snap = pack_out();
    @(negedge clk);
    ref_a = W'(-1000); ref_b = W'(7000); ref_c = W'(-1192);
    repeat (3) @(negedge clk);
    check("R7 hold without strobe", pack_out(), snap);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    check("R7 update on strobe", int'(region), 4);

    // R8: all-positive and all-negative patterns rejected
    snap = pack_out();
    strobe(100, 200, 300);
    check("R8 all positive ignored", pack_out(), snap);
    strobe(-100, -200, -300);
    check("R8 all negative ignored", pack_out(), snap);
    strobe(0, 0, 0);
    check("R8 all zero ignored", pack_out(), snap);

    // R1: reset mid-run restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset", pack_out(), {3'd1, 2'd1, 1'b0, 1'b0, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule